// File: doc/BRIEF.md
# MII Receive Nibble Decoder

This block sits on the MAC side of a four-bit receive interface from an Ethernet PHY and runs in the receive clock domain. It watches the receive-valid, receive-error and data-nibble inputs. It finds the start-of-frame delimiter even when the PHY has dropped part of the preamble. It then packs the nibbles that follow into bytes and passes each byte to the MAC with start, end, error and alignment flags.

When receive-valid is low, the error input together with a data code carries signalling rather than frame data. The block decodes two such codes: the link partner resting in low-power idle, and a false carrier. It also passes the asynchronous carrier and collision inputs through synchronizers. From them it derives carrier, collision and a missing-PHY indication. All three are forced low when the link runs full duplex.

Every emitted byte is delayed by one byte slot. This lets the end flag sit on the last complete byte of the frame rather than arriving as a separate empty beat.

Top module: `mii_rx_decoder`

## Requirements
- R1: Nibbles are packed low nibble first. The first nibble of each pair after the delimiter becomes out_data[3:0] and the second becomes out_data[7:4].
- R2: While hunting, the block locks on a 5 nibble followed directly by a D nibble (byte 8'hD5), both sampled with rx_dv high. This works for any number of leading 5 nibbles, including none. Preamble and delimiter nibbles are never emitted. out_sof is high with the first emitted byte of each frame only.
- R3: A receive-valid burst that never contains the delimiter produces no out_valid pulse.
- R4: The edge that samples rx_dv low ends the frame. After that edge, the last complete byte appears with out_valid and out_eof high, and no earlier byte carries out_eof. A frame that ends before any complete data byte produces no output. out_sof, out_eof, out_err and out_align_err are never high without out_valid.
- R5: If rx_er is sampled high while rx_dv is high at any point in a frame, out_err is high on that frame's out_eof byte. A frame without such a sample has out_err low. The errored nibble is still packed as data.
- R6: If the frame ends after an odd number of nibbles following the delimiter, the leftover nibble is dropped and out_align_err is high on the out_eof byte. Otherwise out_align_err is low.
- R7: One cycle after the block samples rx_dv low, rx_er high and rxd = 4'b0001, lpi_ind is high. It stays high for as long as that input holds, and no data is emitted.
- R8: One cycle after the block samples rx_dv low, rx_er high and rxd = 4'b1110, false_carrier is high for that sample only.
- R9: With rx_dv low and rx_er high, any other rxd value raises neither lpi_ind nor false_carrier.
- R10: crs and col each pass through a two-stage synchronizer. In half duplex, carrier and collision follow them after two clock edges, and after one edge they still show the old value.
- R11: In half duplex, phy_absent is high exactly when the synchronized col is high and the synchronized crs is low.
- R12: With half_duplex low, carrier, collision and phy_absent are all low whatever crs and col do.
- R13: While rst is high and on the first cycle after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| half_duplex | input | 1 | High when the link runs half duplex |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error / out-of-band signalling qualifier |
| rxd | input | 4 | Receive data nibble |
| crs | input | 1 | Carrier sense, asynchronous |
| col | input | 1 | Collision, asynchronous |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | out_data and the flags are valid this cycle |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last complete byte of a frame |
| out_err | output | 1 | Frame contained a receive error (on out_eof byte) |
| out_align_err | output | 1 | Odd trailing nibble dropped (on out_eof byte) |
| lpi_ind | output | 1 | Link partner in low-power idle |
| false_carrier | output | 1 | False-carrier event pulse |
| carrier | output | 1 | Synchronized carrier, masked in full duplex |
| collision | output | 1 | Synchronized collision, masked in full duplex |
| phy_absent | output | 1 | Collision without carrier, masked in full duplex |

## Verification
Suppose the hunt state is wrong, for instance a lock that comes one nibble late. Every byte of the frame then shows up with its nibbles swapped or shifted, and the failure is visible on the first out_valid after the delimiter. If the nibble phase leaks from one frame into the next, the wrong alignment flag appears on the very next end byte. If the held-byte slot is mishandled, the last byte goes missing or the frame arrives with the wrong byte count. The synchronizer depth is visible to the exact edge on carrier and collision, and a wrong mask or combination shows up at once on phy_absent.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] PRE_NIB   = 4'h5;
    localparam logic [NIB_W-1:0] SFD_HI    = 4'hD;
    localparam logic [NIB_W-1:0] LPI_CODE  = 4'h1;
    localparam logic [NIB_W-1:0] FCAR_CODE = 4'hE;

    typedef enum logic {ST_HUNT, ST_DATA} frm_state_e;

    typedef struct packed {
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] d;
    } nib_in_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              err;
        logic              align;
    } byte_ev_t;

    function automatic logic is_delim(input logic [NIB_W-1:0] prev,
                                      input logic [NIB_W-1:0] cur);
        return (prev == PRE_NIB) && (cur == SFD_HI);
    endfunction

    function automatic logic oob_match(input nib_in_t n,
                                       input logic [NIB_W-1:0] code);
        return !n.dv && n.er && (n.d == code);
    endfunction

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mrx_oob.sv
module mrx_oob
    import mrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  nib_in_t nin,
    output logic    lpi,
    output logic    fcar
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lpi  <= 1'b0;
            fcar <= 1'b0;
        end else begin
            lpi  <= oob_match(nin, LPI_CODE);
            fcar <= oob_match(nin, FCAR_CODE);
        end
    end
endmodule

// File: rtl/mrx_framer.sv
module mrx_framer
    import mrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  nib_in_t  nin,
    output byte_ev_t ev,
    output logic     ev_valid
);
    frm_state_e        st;
    logic [NIB_W-1:0]  prev_nib;
    logic              prev_ok;
    logic [NIB_W-1:0]  low_nib;
    logic              phase;
    logic              err_acc;
    logic [BYTE_W-1:0] held_data;
    logic              held_sof;
    logic              held_ok;
    logic              first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_HUNT;
            prev_nib   <= '0;
            prev_ok    <= 1'b0;
            low_nib    <= '0;
            phase      <= 1'b0;
            err_acc    <= 1'b0;
            held_data  <= '0;
            held_sof   <= 1'b0;
            held_ok    <= 1'b0;
            first_pend <= 1'b0;
            ev         <= '0;
            ev_valid   <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            ev       <= '0;
            if (!nin.dv) begin
                // frame boundary: flush the held byte as the last one
                if (st == ST_DATA && held_ok) begin
                    ev_valid <= 1'b1;
                    ev       <= '{data: held_data, sof: held_sof, eof: 1'b1,
                                  err: err_acc, align: phase};
                end
                st         <= ST_HUNT;
                prev_ok    <= 1'b0;
                phase      <= 1'b0;
                held_ok    <= 1'b0;
                err_acc    <= 1'b0;
                first_pend <= 1'b0;
            end else begin
                err_acc  <= err_acc | nin.er;
                prev_nib <= nin.d;
                prev_ok  <= 1'b1;
                if (st == ST_HUNT) begin
                    if (prev_ok && is_delim(prev_nib, nin.d)) begin
                        st         <= ST_DATA;
                        phase      <= 1'b0;
                        first_pend <= 1'b1;
                    end
                end else if (!phase) begin
                    low_nib <= nin.d;
                    phase   <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (held_ok) begin
                        ev_valid <= 1'b1;
                        ev       <= '{data: held_data, sof: held_sof, eof: 1'b0,
                                      err: 1'b0, align: 1'b0};
                    end
                    held_data  <= {nin.d, low_nib};
                    held_sof   <= first_pend;
                    held_ok    <= 1'b1;
                    first_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mii_rx_decoder.sv
module mii_rx_decoder
    import mrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      half_duplex,
    input  logic                      rx_dv,
    input  logic                      rx_er,
    input  logic [mrx_pkg::NIB_W-1:0] rxd,
    input  logic                      crs,
    input  logic                      col,
    output logic [mrx_pkg::BYTE_W-1:0] out_data,
    output logic                      out_valid,
    output logic                      out_sof,
    output logic                      out_eof,
    output logic                      out_err,
    output logic                      out_align_err,
    output logic                      lpi_ind,
    output logic                      false_carrier,
    output logic                      carrier,
    output logic                      collision,
    output logic                      phy_absent
);
    nib_in_t  nin;
    byte_ev_t ev;
    logic     ev_valid;
    logic [1:0] st_sync;

    assign nin = '{dv: rx_dv, er: rx_er, d: rxd};

    mrx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .nin      (nin),
        .ev       (ev),
        .ev_valid (ev_valid)
    );

    mrx_oob u_oob (
        .clk  (clk),
        .rst  (rst),
        .nin  (nin),
        .lpi  (lpi_ind),
        .fcar (false_carrier)
    );

    mrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({col, crs}),
        .q_sync  (st_sync)
    );

    assign out_data      = ev.data;
    assign out_valid     = ev_valid;
    assign out_sof       = ev.sof;
    assign out_eof       = ev.eof;
    assign out_err       = ev.err;
    assign out_align_err = ev.align;

    assign carrier    = half_duplex & st_sync[0];
    assign collision  = half_duplex & st_sync[1];
    assign phy_absent = half_duplex & st_sync[1] & ~st_sync[0];
endmodule

// File: rtl/mii_rx_decoder_chk.sv
module mii_rx_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       half_duplex,
    input logic       rx_dv,
    input logic       rx_er,
    input logic [3:0] rxd,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic       out_err,
    input logic       out_align_err,
    input logic       lpi_ind,
    input logic       false_carrier,
    input logic       carrier,
    input logic       phy_absent
);
    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst)                       in_frame <= 1'b0;
        else if (out_valid && out_eof) in_frame <= 1'b0;
        else if (out_valid && out_sof) in_frame <= 1'b1;
    end

    assert_flags_need_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof || out_err || out_align_err) |-> out_valid);

    assert_eof_after_dv_low_R4: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> !$past(rx_dv));

    assert_single_sof_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> !in_frame);

    assert_fcar_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (false_carrier == $past(!rx_dv && rx_er && rxd == 4'hE)));

    assert_lpi_level_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lpi_ind == $past(!rx_dv && rx_er && rxd == 4'h1)));

    assert_duplex_mask_R12: assert property (@(posedge clk) disable iff (rst)
        !half_duplex |-> !(carrier || phy_absent));

    assert_absent_no_carrier_R11: assert property (@(posedge clk) disable iff (rst)
        phy_absent |-> !carrier);
endmodule

bind mii_rx_decoder mii_rx_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .half_duplex   (half_duplex),
    .rx_dv         (rx_dv),
    .rx_er         (rx_er),
    .rxd           (rxd),
    .out_valid     (out_valid),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .out_err       (out_err),
    .out_align_err (out_align_err),
    .lpi_ind       (lpi_ind),
    .false_carrier (false_carrier),
    .carrier       (carrier),
    .phy_absent    (phy_absent)
);

// File: tb/mii_rx_decoder_test.sv
`timescale 1ns/1ps
module mii_rx_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_duplex = 1'b1;
    logic       rx_dv = 1'b0, rx_er = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       crs = 1'b0, col = 1'b0;
    logic [7:0] out_data;
    logic out_valid, out_sof, out_eof, out_err, out_align_err;
    logic lpi_ind, false_carrier, carrier, collision, phy_absent;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mii_rx_decoder uut (
        .clk(clk), .rst(rst), .half_duplex(half_duplex),
        .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .crs(crs), .col(col),
        .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err), .out_align_err(out_align_err),
        .lpi_ind(lpi_ind), .false_carrier(false_carrier), .carrier(carrier),
        .collision(collision), .phy_absent(phy_absent)
    );

    // capture of emitted bytes
    logic [7:0] cap_d [64];
    logic       cap_s [64], cap_e [64], cap_r [64], cap_a [64];
    int         ncap = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && ncap < 64) begin
            cap_d[ncap] = out_data;
            cap_s[ncap] = out_sof;
            cap_e[ncap] = out_eof;
            cap_r[ncap] = out_err;
            cap_a[ncap] = out_align_err;
            ncap++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nib(input logic dv, input logic er, input logic [3:0] d);
        @(negedge clk);
        rx_dv = dv; rx_er = er; rxd = d;
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(seed * 37 + i * 29);
    endfunction

    // {seed[31:25], odd[24], err_idx[23:16] (FF none), nbytes[15:8], preamble[7:0]}
    localparam logic [31:0] VECS [6] = '{
        {7'd3,  1'b0, 8'hFF, 8'd4, 8'd0},
        {7'd11, 1'b0, 8'hFF, 8'd6, 8'd13},
        {7'd20, 1'b0, 8'd2,  8'd5, 8'd14},
        {7'd33, 1'b1, 8'hFF, 8'd3, 8'd7},
        {7'd45, 1'b1, 8'd0,  8'd1, 8'd8},
        {7'd60, 1'b0, 8'd7,  8'd8, 8'd1}
    };

    task automatic run_frame(input int pre, input int nb, input int eidx,
                             input logic odd, input int seed);
        ncap = 0;
        for (int k = 0; k < pre; k++) nib(1'b1, 1'b0, 4'h5);
        nib(1'b1, 1'b0, 4'h5);
        nib(1'b1, 1'b0, 4'hD);
        for (int b = 0; b < nb; b++) begin
            logic [7:0] v;
            v = pbyte(seed, b);
            nib(1'b1, (b == eidx), v[3:0]);
            nib(1'b1, 1'b0, v[7:4]);
        end
        if (odd) nib(1'b1, 1'b0, 4'hA);
        nib(1'b0, 1'b0, 4'h0);
        repeat (3) @(negedge clk);
        check("R4 byte count", ncap, nb);
        for (int b = 0; b < nb && b < ncap; b++) begin
            check("R1 byte value", cap_d[b], pbyte(seed, b));
            check("R2 sof flag", cap_s[b], (b == 0));
            check("R4 eof flag", cap_e[b], (b == nb - 1));
            check("R5 err flag", cap_r[b], (b == nb - 1) && (eidx != 8'hFF));
            check("R6 align flag", cap_a[b], (b == nb - 1) && odd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: outputs low during reset
        check("R13 reset outputs",
              {out_valid, out_sof, out_eof, out_err, out_align_err, lpi_ind,
               false_carrier, carrier, collision, phy_absent}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R13 first cycle after reset",
              {out_valid, lpi_ind, false_carrier, carrier, collision, phy_absent}, 0);
        repeat (2) @(negedge clk);

        // table-driven frames: R1 R2 R4 R5 R6
        foreach (VECS[i]) begin
            run_frame(int'(VECS[i][7:0]), int'(VECS[i][15:8]), int'(VECS[i][23:16]),
                      VECS[i][24], int'(VECS[i][31:25]));
            repeat (2) @(negedge clk);
        end

        // R3: burst with no delimiter
        ncap = 0;
        for (int k = 0; k < 10; k++) nib(1'b1, 1'b0, 4'h5);
        nib(1'b1, 1'b0, 4'h3);
        nib(1'b0, 1'b0, 4'h0);
        repeat (3) @(negedge clk);
        check("R3 no output without delimiter", ncap, 0);

        // R4: frame ending right after delimiter, and with one nibble
        ncap = 0;
        nib(1'b1, 1'b0, 4'h5); nib(1'b1, 1'b0, 4'h5); nib(1'b1, 1'b0, 4'hD);
        nib(1'b1, 1'b0, 4'h7);
        nib(1'b0, 1'b0, 4'h0);
        repeat (3) @(negedge clk);
        check("R4 no output for empty frame", ncap, 0);

        // R7: low-power idle level
        nib(1'b0, 1'b1, 4'h1);
        @(negedge clk);
        check("R7 lpi high", lpi_ind, 1);
        check("R7 lpi held", false_carrier, 0);
        @(negedge clk);
        check("R7 lpi still high", lpi_ind, 1);
        check("R7 no data during lpi", out_valid, 0);

        // R8: false carrier pulse
        rxd = 4'hE;
        @(negedge clk);
        check("R8 false carrier high", false_carrier, 1);
        check("R8 lpi dropped", lpi_ind, 0);
        rx_er = 1'b0; rxd = 4'h0;
        @(negedge clk);
        check("R8 false carrier pulse ends", false_carrier, 0);

        // R9: other codes ignored
        rx_er = 1'b1; rxd = 4'h5;
        @(negedge clk);
        check("R9 other code", {lpi_ind, false_carrier}, 0);
        rxd = 4'hF;
        @(negedge clk);
        check("R9 other code F", {lpi_ind, false_carrier, out_valid}, 0);
        rx_er = 1'b0; rxd = 4'h0;
        @(negedge clk);

        // R10: synchronizer latency
        crs = 1'b1;
        @(negedge clk);
        check("R10 carrier after one edge", carrier, 0);
        @(negedge clk);
        check("R10 carrier after two edges", carrier, 1);
        col = 1'b1;
        @(negedge clk);
        check("R10 collision after one edge", collision, 0);
        @(negedge clk);
        check("R10 collision after two edges", collision, 1);
        check("R11 no absent with carrier", phy_absent, 0);

        // R11: col without crs
        crs = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 phy absent", phy_absent, 1);
        check("R11 carrier low", carrier, 0);

        // R12: full duplex masks
        half_duplex = 1'b0;
        #1;
        check("R12 masked in full duplex", {carrier, collision, phy_absent}, 0);
        crs = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 still masked", {carrier, collision, phy_absent}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule